// File: doc/BRIEF.md
# Exception Entry Controller

This block sits beside the pipeline of a small processor core and performs the state update that happens when an exception is taken. The pipeline presents a general exception request with the PC of the faulting instruction, a cause code and, when the fault concerns a memory access, the virtual address involved. Separately it may present a debug request with its own cause code. The block decides whether the request is a first-level exception, a nested (double) exception or a debug entry. It then writes the PC, cause, address and processor-status registers, and one cycle later emits a single-cycle redirect carrying a vector identifier. The fetch unit turns that identifier into an address.

The processor-status word holds three fields: an exception-mode flag, a user-mode flag and a current interrupt level. Debug entry saves the PC and the previous status word into a bank of per-level save registers, indexed by the configured debug level. It then raises the interrupt level to that debug level, so that further debug requests are masked until software lowers it. The pipeline can also load the status word through a write port, for example when an exception handler returns.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset every status field, save register, bank entry and the redirect strobe are zero, and the vector output reads kernel (0).
- R2: A general request taken while the exception-mode flag is clear writes the PC into the level-1 save register. The redirect carries the user vector (1) when the user-mode flag is set and the kernel vector (0) when it is clear.
- R3: A general request taken while the exception-mode flag is set carries the double vector (2). With the dedicated double-save option enabled, the PC goes into the double save register and the level-1 save register keeps its value. With the option disabled, the PC goes into the level-1 save register.
- R4: Every general request writes its cause code into the cause register and sets the exception-mode flag. The user-mode flag and the interrupt level are unchanged.
- R5: The fault-address register loads the request address only when the request marks the address as valid. Otherwise it keeps its value.
- R6: A debug request is dropped, with no register change and no redirect, when the current interrupt level is at or above the configured debug level (level 4 in the default build).
- R7: A taken debug request writes its cause into the debug-cause register. It stores the PC and the old status word in the bank entry for the debug level, with the status word packed as bit 0 exception-mode, bit 1 user-mode and bits 5:2 interrupt level. It sets the interrupt level to the debug level and sets the exception-mode flag, leaves user-mode unchanged, leaves the other bank entries untouched and redirects with the debug vector (3).
- R8: When a general and a debug request arrive in the same cycle, only the general request is taken. A debug request still held in the next cycle is evaluated against the updated status word.
- R9: The status write port loads all three status fields in a cycle in which no exception or debug entry is taken. An entry taken in the same cycle takes precedence and the write is discarded.
- R10: The redirect strobe is high in the cycle after each taken request and low in the cycle after any cycle in which nothing is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | General exception request |
| exc_pc | input | XLEN | PC of the faulting instruction (also used for debug entry) |
| exc_cause | input | CAUSE_W | General exception cause code |
| exc_has_vaddr | input | 1 | Request carries a valid fault address |
| exc_vaddr | input | XLEN | Fault virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| ps_wr_en | input | 1 | Status-word write strobe |
| ps_wr_excm | input | 1 | Exception-mode value to write |
| ps_wr_um | input | 1 | User-mode value to write |
| ps_wr_intlevel | input | 4 | Interrupt level to write |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_vec | output | 2 | Vector id: 0 kernel, 1 user, 2 double, 3 debug |
| ps_excm_o | output | 1 | Exception-mode flag |
| ps_um_o | output | 1 | User-mode flag |
| ps_intlevel_o | output | 4 | Current interrupt level |
| epc1_o | output | XLEN | Level-1 saved PC |
| depc_o | output | XLEN | Double-exception saved PC |
| exccause_o | output | CAUSE_W | Last general cause |
| excvaddr_o | output | XLEN | Last fault address |
| debugcause_o | output | DCAUSE_W | Last debug cause |
| epc_bank_o | output | (DBG_LEVEL-1)*XLEN | Saved PCs for levels 2..DBG_LEVEL, level 2 in the low slice |
| eps_bank_o | output | (DBG_LEVEL-1)*6 | Saved status words for levels 2..DBG_LEVEL, level 2 in the low slice |

## Verification
On every cycle the assertions check several properties. A general request always redirects on the next cycle with a non-debug vector, and a nested request selects the double vector. The cause lands in the cause register, every redirect coincides with the exception-mode flag set, and a debug redirect comes with the interrupt level at the debug level. A masked debug request changes nothing. Only the bench's scenarios can show the data paths that need a known history: which save register received the PC, the packed old status word in the bank and the untouched neighbouring bank entries. They also cover the follow-up evaluation of a debug request that lost to a general one, and the discarded status write.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int PS_ILVL_W = 4;
    localparam int PS_W      = PS_ILVL_W + 2;

    typedef enum logic [1:0] {
        VEC_KERNEL = 2'd0,
        VEC_USER   = 2'd1,
        VEC_DOUBLE = 2'd2,
        VEC_DEBUG  = 2'd3
    } exc_vec_e;

    // bit 0 exception-mode, bit 1 user-mode, upper bits interrupt level
    typedef struct packed {
        logic [PS_ILVL_W-1:0] intlevel;
        logic                 um;
        logic                 excm;
    } ps_t;

endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_entry_pkg::*;
#(
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic     ps_excm,
    input  logic     ps_um,
    output exc_vec_e vec,
    output logic     save_to_depc
);

    always_comb begin
        if (ps_excm) begin
            vec = VEC_DOUBLE;
        end else if (ps_um) begin
            vec = VEC_USER;
        end else begin
            vec = VEC_KERNEL;
        end
        save_to_depc = ps_excm && HAS_DEPC;
    end

endmodule

// File: rtl/exc_dbg_gate.sv
module exc_dbg_gate
    import exc_entry_pkg::*;
#(
    parameter int DBG_LEVEL = 4
) (
    input  logic                 dbg_req,
    input  logic                 exc_req,
    input  logic [PS_ILVL_W-1:0] cur_level,
    output logic                 dbg_take
);

    localparam logic [PS_ILVL_W-1:0] DBG_LVL_V = PS_ILVL_W'(DBG_LEVEL);

    always_comb begin
        dbg_take = dbg_req && !exc_req && (cur_level < DBG_LVL_V);
    end

endmodule

// File: rtl/exc_lvl_bank.sv
module exc_lvl_bank
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int DBG_LEVEL = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PS_ILVL_W-1:0]      wr_lvl,
    input  logic [XLEN-1:0]           wr_pc,
    input  ps_t                       wr_ps,
    output logic [(DBG_LEVEL-1)*XLEN-1:0] epc_flat,
    output logic [(DBG_LEVEL-1)*PS_W-1:0] eps_flat
);

    localparam int NLVL   = DBG_LEVEL - 1;
    localparam int LVL_LO = 2;

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        localparam logic [PS_ILVL_W-1:0] MY_LVL = PS_ILVL_W'(g + LVL_LO);
        logic [XLEN-1:0] epc_d, epc_q;
        ps_t             eps_d, eps_q;

        always_comb begin
            epc_d = epc_q;
            eps_d = eps_q;
            if (wr_en && (wr_lvl == MY_LVL)) begin
                epc_d = wr_pc;
                eps_d = wr_ps;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                epc_q <= '0;
                eps_q <= '0;
            end else begin
                epc_q <= epc_d;
                eps_q <= eps_d;
            end
        end

        assign epc_flat[g*XLEN +: XLEN] = epc_q;
        assign eps_flat[g*PS_W +: PS_W] = eps_q;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 6,
    parameter int DCAUSE_W  = 4,
    parameter int DBG_LEVEL = 4,
    parameter bit HAS_DEPC  = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          exc_req,
    input  logic [XLEN-1:0]               exc_pc,
    input  logic [CAUSE_W-1:0]            exc_cause,
    input  logic                          exc_has_vaddr,
    input  logic [XLEN-1:0]               exc_vaddr,
    input  logic                          dbg_req,
    input  logic [DCAUSE_W-1:0]           dbg_cause,
    input  logic                          ps_wr_en,
    input  logic                          ps_wr_excm,
    input  logic                          ps_wr_um,
    input  logic [PS_ILVL_W-1:0]          ps_wr_intlevel,
    output logic                          redirect_valid,
    output logic [1:0]                    redirect_vec,
    output logic                          ps_excm_o,
    output logic                          ps_um_o,
    output logic [PS_ILVL_W-1:0]          ps_intlevel_o,
    output logic [XLEN-1:0]               epc1_o,
    output logic [XLEN-1:0]               depc_o,
    output logic [CAUSE_W-1:0]            exccause_o,
    output logic [XLEN-1:0]               excvaddr_o,
    output logic [DCAUSE_W-1:0]           debugcause_o,
    output logic [(DBG_LEVEL-1)*XLEN-1:0] epc_bank_o,
    output logic [(DBG_LEVEL-1)*PS_W-1:0] eps_bank_o
);

    localparam logic [PS_ILVL_W-1:0] DBG_LVL_V = PS_ILVL_W'(DBG_LEVEL);

    typedef struct packed {
        ps_t                 ps;
        logic [XLEN-1:0]     epc1;
        logic [XLEN-1:0]     depc;
        logic [XLEN-1:0]     excvaddr;
        logic [CAUSE_W-1:0]  exccause;
        logic [DCAUSE_W-1:0] debugcause;
        logic                redir_v;
        exc_vec_e            redir_vec;
    } state_t;

    state_t   st_d, st_q;
    exc_vec_e gen_vec;
    logic     save_to_depc;
    logic     dbg_take;

    exc_vec_sel #(.HAS_DEPC(HAS_DEPC)) u_vec_sel (
        .ps_excm      (st_q.ps.excm),
        .ps_um        (st_q.ps.um),
        .vec          (gen_vec),
        .save_to_depc (save_to_depc)
    );

    exc_dbg_gate #(.DBG_LEVEL(DBG_LEVEL)) u_dbg_gate (
        .dbg_req   (dbg_req),
        .exc_req   (exc_req),
        .cur_level (st_q.ps.intlevel),
        .dbg_take  (dbg_take)
    );

    exc_lvl_bank #(.XLEN(XLEN), .DBG_LEVEL(DBG_LEVEL)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dbg_take),
        .wr_lvl   (DBG_LVL_V),
        .wr_pc    (exc_pc),
        .wr_ps    (st_q.ps),
        .epc_flat (epc_bank_o),
        .eps_flat (eps_bank_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.redir_v = 1'b0;
        if (exc_req) begin
            if (exc_has_vaddr) begin
                st_d.excvaddr = exc_vaddr;
            end
            if (save_to_depc) begin
                st_d.depc = exc_pc;
            end else begin
                st_d.epc1 = exc_pc;
            end
            st_d.exccause  = exc_cause;
            st_d.ps.excm   = 1'b1;
            st_d.redir_v   = 1'b1;
            st_d.redir_vec = gen_vec;
        end else if (dbg_take) begin
            st_d.debugcause  = dbg_cause;
            st_d.ps.intlevel = DBG_LVL_V;
            st_d.ps.excm     = 1'b1;
            st_d.redir_v     = 1'b1;
            st_d.redir_vec   = VEC_DEBUG;
        end else if (ps_wr_en) begin
            st_d.ps.excm     = ps_wr_excm;
            st_d.ps.um       = ps_wr_um;
            st_d.ps.intlevel = ps_wr_intlevel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid = st_q.redir_v;
    assign redirect_vec   = st_q.redir_vec;
    assign ps_excm_o      = st_q.ps.excm;
    assign ps_um_o        = st_q.ps.um;
    assign ps_intlevel_o  = st_q.ps.intlevel;
    assign epc1_o         = st_q.epc1;
    assign depc_o         = st_q.depc;
    assign exccause_o     = st_q.exccause;
    assign excvaddr_o     = st_q.excvaddr;
    assign debugcause_o   = st_q.debugcause;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int CAUSE_W   = 6,
    parameter int DCAUSE_W  = 4,
    parameter int DBG_LEVEL = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 exc_req,
    input logic [CAUSE_W-1:0]   exc_cause,
    input logic                 dbg_req,
    input logic                 redirect_valid,
    input logic [1:0]           redirect_vec,
    input logic                 ps_excm_o,
    input logic [PS_ILVL_W-1:0] ps_intlevel_o,
    input logic [CAUSE_W-1:0]   exccause_o,
    input logic [DCAUSE_W-1:0]  debugcause_o
);

    localparam logic [PS_ILVL_W-1:0] DBG_LVL_V = PS_ILVL_W'(DBG_LEVEL);

    AST_GEN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (redirect_valid && redirect_vec != 2'd3)); // R8

    AST_DOUBLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && ps_excm_o) |=> (redirect_vec == 2'd2)); // R3

    AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (exccause_o == $past(exc_cause))); // R4

    AST_EXCM_ON_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> ps_excm_o); // R4

    AST_DBG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && redirect_vec == 2'd3) |-> (ps_intlevel_o == DBG_LVL_V)); // R7

    AST_DBG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !exc_req && ps_intlevel_o >= DBG_LVL_V)
            |=> (!redirect_valid && $stable(debugcause_o))); // R6

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req && !dbg_req) |=> !redirect_valid); // R10

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .CAUSE_W   (CAUSE_W),
    .DCAUSE_W  (DCAUSE_W),
    .DBG_LEVEL (DBG_LEVEL)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .exc_req        (exc_req),
    .exc_cause      (exc_cause),
    .dbg_req        (dbg_req),
    .redirect_valid (redirect_valid),
    .redirect_vec   (redirect_vec),
    .ps_excm_o      (ps_excm_o),
    .ps_intlevel_o  (ps_intlevel_o),
    .exccause_o     (exccause_o),
    .debugcause_o   (debugcause_o)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;

    localparam int XLEN     = 32;
    localparam int CW       = 6;
    localparam int DCW      = 4;
    localparam int DBG      = 4;
    localparam bit HAS_DEPC = 1'b1;
    localparam int NLVL     = DBG - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            exc_req = 1'b0;
    logic [XLEN-1:0] exc_pc = '0;
    logic [CW-1:0]   exc_cause = '0;
    logic            exc_has_vaddr = 1'b0;
    logic [XLEN-1:0] exc_vaddr = '0;
    logic            dbg_req = 1'b0;
    logic [DCW-1:0]  dbg_cause = '0;
    logic            ps_wr_en = 1'b0;
    logic            ps_wr_excm = 1'b0;
    logic            ps_wr_um = 1'b0;
    logic [3:0]      ps_wr_intlevel = '0;

    logic                 redirect_valid;
    logic [1:0]           redirect_vec;
    logic                 ps_excm_o, ps_um_o;
    logic [3:0]           ps_intlevel_o;
    logic [XLEN-1:0]      epc1_o, depc_o, excvaddr_o;
    logic [CW-1:0]        exccause_o;
    logic [DCW-1:0]       debugcause_o;
    logic [NLVL*XLEN-1:0] epc_bank_o;
    logic [NLVL*6-1:0]    eps_bank_o;

    always #2 clk = ~clk;

    exc_entry_ctrl #(
        .XLEN(XLEN), .CAUSE_W(CW), .DCAUSE_W(DCW), .DBG_LEVEL(DBG), .HAS_DEPC(HAS_DEPC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_pc(exc_pc),
        .exc_cause(exc_cause), .exc_has_vaddr(exc_has_vaddr), .exc_vaddr(exc_vaddr),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause), .ps_wr_en(ps_wr_en),
        .ps_wr_excm(ps_wr_excm), .ps_wr_um(ps_wr_um), .ps_wr_intlevel(ps_wr_intlevel),
        .redirect_valid(redirect_valid), .redirect_vec(redirect_vec),
        .ps_excm_o(ps_excm_o), .ps_um_o(ps_um_o), .ps_intlevel_o(ps_intlevel_o),
        .epc1_o(epc1_o), .depc_o(depc_o), .exccause_o(exccause_o),
        .excvaddr_o(excvaddr_o), .debugcause_o(debugcause_o),
        .epc_bank_o(epc_bank_o), .eps_bank_o(eps_bank_o)
    );

    // behavioural reference state
    int unsigned m_excm, m_um, m_il, m_rv, m_vec;
    logic [XLEN-1:0] m_epc1, m_depc, m_vaddr;
    int unsigned m_cause, m_dcause;
    logic [XLEN-1:0] m_bpc [NLVL];
    int unsigned     m_bps [NLVL];

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_excm = 0; m_um = 0; m_il = 0; m_rv = 0; m_vec = 0;
        m_epc1 = '0; m_depc = '0; m_vaddr = '0; m_cause = 0; m_dcause = 0;
        for (int i = 0; i < NLVL; i++) begin
            m_bpc[i] = '0;
            m_bps[i] = 0;
        end
    endtask

    task automatic compare_all();
        check("R10", "redirect_valid", longint'(redirect_valid), longint'(m_rv));
        check("R2",  "redirect_vec",   longint'(redirect_vec), longint'(m_vec));
        check("R4",  "ps_excm",        longint'(ps_excm_o), longint'(m_excm));
        check("R4",  "ps_um",          longint'(ps_um_o), longint'(m_um));
        check("R7",  "ps_intlevel",    longint'(ps_intlevel_o), longint'(m_il));
        check("R2",  "epc1",           longint'(epc1_o), longint'(m_epc1));
        check("R3",  "depc",           longint'(depc_o), longint'(m_depc));
        check("R4",  "exccause",       longint'(exccause_o), longint'(m_cause));
        check("R5",  "excvaddr",       longint'(excvaddr_o), longint'(m_vaddr));
        check("R7",  "debugcause",     longint'(debugcause_o), longint'(m_dcause));
        for (int i = 0; i < NLVL; i++) begin
            check("R7", $sformatf("epc_bank[%0d]", i + 2),
                  longint'(epc_bank_o[i*XLEN +: XLEN]), longint'(m_bpc[i]));
            check("R7", $sformatf("eps_bank[%0d]", i + 2),
                  longint'(eps_bank_o[i*6 +: 6]), longint'(m_bps[i]));
        end
    endtask

    // compute the model's next state from present inputs, pass one edge, compare
    task automatic tick();
        int unsigned n_excm, n_um, n_il, n_rv, n_vec, n_cause, n_dcause;
        logic [XLEN-1:0] n_epc1, n_depc, n_vaddr;
        n_excm = m_excm; n_um = m_um; n_il = m_il; n_rv = 0; n_vec = m_vec;
        n_cause = m_cause; n_dcause = m_dcause;
        n_epc1 = m_epc1; n_depc = m_depc; n_vaddr = m_vaddr;
        if (exc_req) begin
            if (exc_has_vaddr) n_vaddr = exc_vaddr;
            if (m_excm == 1 && HAS_DEPC) n_depc = exc_pc;
            else n_epc1 = exc_pc;
            n_vec = (m_excm == 1) ? 2 : ((m_um == 1) ? 1 : 0);
            n_cause = exc_cause;
            n_excm = 1;
            n_rv = 1;
        end else if (dbg_req && m_il < DBG) begin
            n_dcause = dbg_cause;
            m_bpc[DBG-2] = exc_pc;
            m_bps[DBG-2] = m_il * 4 + m_um * 2 + m_excm;
            n_il = DBG;
            n_excm = 1;
            n_rv = 1;
            n_vec = 3;
        end else if (ps_wr_en) begin
            n_excm = ps_wr_excm; n_um = ps_wr_um; n_il = ps_wr_intlevel;
        end
        @(negedge clk);
        m_excm = n_excm; m_um = n_um; m_il = n_il; m_rv = n_rv; m_vec = n_vec;
        m_cause = n_cause; m_dcause = n_dcause;
        m_epc1 = n_epc1; m_depc = n_depc; m_vaddr = n_vaddr;
        compare_all();
    endtask

    task automatic idle();
        exc_req = 0; dbg_req = 0; ps_wr_en = 0; exc_has_vaddr = 0;
    endtask

    task automatic write_ps(input int unsigned excm, input int unsigned um,
                            input int unsigned il);
        idle();
        ps_wr_en = 1; ps_wr_excm = excm[0]; ps_wr_um = um[0]; ps_wr_intlevel = il[3:0];
        tick();
        idle();
    endtask

    task automatic gen_exc(input logic [XLEN-1:0] pc, input int unsigned cause,
                           input bit hv, input logic [XLEN-1:0] va);
        idle();
        exc_req = 1; exc_pc = pc; exc_cause = cause[CW-1:0];
        exc_has_vaddr = hv; exc_vaddr = va;
        tick();
        idle();
    endtask

    task automatic dbg_exc(input logic [XLEN-1:0] pc, input int unsigned cause);
        idle();
        dbg_req = 1; exc_pc = pc; dbg_cause = cause[DCW-1:0];
        tick();
        idle();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all();                                   // R1 reset state
        check("R1", "redirect after reset", longint'(redirect_valid), 0);

        // R2/R5: kernel entry with a fault address
        gen_exc(32'h0000_1000, 5, 1'b1, 32'hDEAD_0040);
        check("R2", "kernel vector", longint'(redirect_vec), 0);
        check("R5", "vaddr loaded", longint'(excvaddr_o), longint'(32'hDEAD_0040));
        tick();
        check("R10", "redirect single cycle", longint'(redirect_valid), 0);

        // R3: nested request while excm set -> double vector, DEPC written
        gen_exc(32'h0000_2000, 9, 1'b0, 32'h1111_1111);
        check("R3", "double vector", longint'(redirect_vec), 2);
        check("R3", "epc1 kept", longint'(epc1_o), longint'(32'h0000_1000));
        check("R3", "depc", longint'(depc_o), longint'(32'h0000_2000));
        check("R5", "vaddr kept", longint'(excvaddr_o), longint'(32'hDEAD_0040));

        // R9/R2: user mode entry
        write_ps(0, 1, 0);
        gen_exc(32'h0000_3000, 3, 1'b0, '0);
        check("R2", "user vector", longint'(redirect_vec), 1);
        check("R4", "um kept", longint'(ps_um_o), 1);

        // R7: debug entry taken from level 2 with user mode set
        write_ps(0, 1, 2);
        dbg_exc(32'h0000_4000, 7);
        check("R7", "debug vector", longint'(redirect_vec), 3);
        check("R7", "intlevel raised", longint'(ps_intlevel_o), DBG);
        check("R7", "eps old ps", longint'(eps_bank_o[(DBG-2)*6 +: 6]), 2*4 + 2);

        // R6: masked at the debug level and above, taken just below
        dbg_exc(32'h0000_5000, 1);
        check("R6", "masked at level", longint'(redirect_valid), 0);
        write_ps(0, 0, 5);
        dbg_exc(32'h0000_5100, 2);
        check("R6", "masked above level", longint'(redirect_valid), 0);
        write_ps(0, 0, 3);
        dbg_exc(32'h0000_5200, 6);
        check("R6", "taken just below level", longint'(redirect_valid), 1);

        // R8: simultaneous requests; debug held into the next cycle
        write_ps(0, 0, 0);
        idle();
        exc_req = 1; dbg_req = 1; exc_pc = 32'h0000_6000; exc_cause = 6'd12; dbg_cause = 4'd9;
        tick();
        check("R8", "general wins", longint'(redirect_vec), 0);
        exc_req = 0; exc_pc = 32'h0000_6004;
        tick();
        check("R8", "held debug taken", longint'(redirect_vec), 3);
        check("R8", "debug pc", longint'(epc_bank_o[(DBG-2)*XLEN +: XLEN]), longint'(32'h0000_6004));
        idle();

        // R9: status write collides with an exception
        write_ps(0, 0, 1);
        idle();
        exc_req = 1; exc_pc = 32'h0000_7000; exc_cause = 6'd1;
        ps_wr_en = 1; ps_wr_excm = 0; ps_wr_um = 1; ps_wr_intlevel = 4'd9;
        tick();
        check("R9", "write discarded um", longint'(ps_um_o), 0);
        check("R9", "write discarded level", longint'(ps_intlevel_o), 1);
        idle();

        // R10: back-to-back requests keep the strobe high
        exc_req = 1; exc_pc = 32'h0000_8000; tick();
        exc_pc = 32'h0000_8004; tick();
        check("R10", "back-to-back strobe", longint'(redirect_valid), 1);
        idle();
        tick();

        // mixed traffic compared against the model on every cycle
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom;
            exc_req = (r % 4) == 0;
            dbg_req = ((r >> 2) % 3) == 0;
            ps_wr_en = ((r >> 4) % 4) == 0;
            ps_wr_excm = r[8]; ps_wr_um = r[9]; ps_wr_intlevel = 4'(r >> 10);
            exc_has_vaddr = r[14];
            exc_pc = $urandom; exc_vaddr = $urandom;
            exc_cause = CW'($urandom); dbg_cause = DCW'($urandom);
            tick();
        end
        idle();
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule